// File: doc/BRIEF.md
# Last-Value Load Predictor with Per-Line Saturating Confidence

This block predicts the value a load will return by remembering the value that the same load returned the last time it ran. A direct-mapped table is indexed by the load's instruction address. Each line holds the last value seen and a small saturating up/down counter. The lookup port takes an address and returns the stored value together with a predict flag. The flag is raised only when the line's counter has reached a threshold that is supplied at run time. The table has no tags, so loads whose addresses land on the same line share that line.

When the true value of a load is known, the pipeline presents the address and the value on the update port with a valid strobe. The block compares the true value with the value the line held. The counter steps up on a match and steps down on a mismatch. The line's value is then overwritten with the true value, whatever the confidence was. The number of lines, the value width, the address width, the counter width and the number of dropped alignment bits are all parameters.

Top module: `lastval_conf_predictor`

## Requirements
- R1: The line is chosen by the address bits [IDX_W+1:2], where IDX_W = log2(LINES). That is the address divided by 4, modulo LINES. The two lowest address bits and all bits above the index field have no effect on which line is used, so addresses that differ by a multiple of LINES*4 share one line.
- R2: After reset, every line holds value 0 and counter 0. A lookup of any address returns 0, and lk_predict is low for any threshold from 1 to 7.
- R3: lk_predict is 1 exactly when the counter of the looked-up line is greater than or equal to thresh. The threshold ranges from 1 to 7 with the default 3-bit counter.
- R4: An update whose up_value equals the value stored in the selected line increments that line's counter by one.
- R5: An update whose up_value differs from the stored value decrements that line's counter by one.
- R6: The counter saturates. It stays at 7 when a match arrives at 7, and it stays at 0 when a mismatch arrives at 0. It never wraps.
- R7: Every update writes up_value into the selected line, whatever the counter value and whatever the comparison result.
- R8: When up_valid is low, no line's value or counter changes, whatever is on up_addr and up_value.
- R9: A lookup in the same cycle as an update to the same line returns the value and predict flag held before that update. The new contents are visible from the next cycle.
- R10: An update changes only the line that its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all values and counters |
| lk_addr | input | ADDR_W | Instruction address of the load being looked up |
| thresh | input | CONF_W | Minimum counter value that allows a prediction |
| lk_value | output | VALUE_W | Value stored in the looked-up line |
| lk_predict | output | 1 | High when the looked-up line's counter is at or above thresh |
| up_valid | input | 1 | Strobe qualifying an update in this cycle |
| up_addr | input | ADDR_W | Instruction address of the load whose true value is known |
| up_value | input | VALUE_W | True loaded value |

## Verification
The bench builds the block with 16 lines, 32-bit addresses, 64-bit values and the default 3-bit counter. With only 16 lines, addresses whose upper bits are randomized alias onto the same line often, and every line can be swept exhaustively after reset and after traffic. Random values are drawn from a set of three, so matches and mismatches are both frequent. A run of nine matching updates is enough to push a counter from 0 against its ceiling of 7, and a run from a full counter reaches the floor, so both saturation points and every threshold from 1 to 7 are exercised directly.

// File: rtl/cvp_pkg.sv
package cvp_pkg;

   // Action applied to the confidence counter of the updated line
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/cvp_index.sv
// Maps an instruction address onto a table line: drop the alignment
// bits, keep the next IDX_W bits (modulo the power-of-two line count).
module cvp_index #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 6,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);

   if (ADDR_W < IDX_W + ALIGN_BITS) begin : g_bad_width
      $error("cvp_index: address too narrow for index field");
   end

   if (ALIGN_BITS == 0) begin : g_no_align
      assign idx = addr[IDX_W-1:0];
   end else begin : g_align
      assign idx = addr[ALIGN_BITS +: IDX_W];
   end

   // Remaining address bits deliberately do not take part in selection
   logic unused_addr_bits;
   assign unused_addr_bits = ^addr;

endmodule

// File: rtl/cvp_value_bank.sv
// Last-value storage: one register per line, combinational read ports,
// and a compare of the stored value against the incoming true value.
module cvp_value_bank #(
   parameter  int LINES   = 64,
   parameter  int VALUE_W = 64,
   localparam int IDX_W   = $clog2(LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [VALUE_W-1:0] rd_value,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VALUE_W-1:0] wr_value,
   output logic               wr_match
);

   logic [VALUE_W-1:0] line_val [LINES];
   logic [VALUE_W-1:0] cur_value;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [VALUE_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            val_q <= wr_value;
         end
      end
      assign line_val[g] = val_q;
   end

   assign rd_value  = line_val[rd_idx];
   assign cur_value = line_val[wr_idx];
   assign wr_match  = (cur_value == wr_value);

endmodule

// File: rtl/cvp_conf_bank.sv
// Per-line saturating up/down confidence counters.
module cvp_conf_bank
   import cvp_pkg::*;
#(
   parameter  int LINES  = 64,
   parameter  int CONF_W = 3,
   localparam int IDX_W  = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CONF_W-1:0] rd_conf,
   input  logic [IDX_W-1:0]  up_idx,
   input  cnt_op_e           up_op,
   output logic [CONF_W-1:0] up_conf
);

   localparam logic [CONF_W-1:0] CONF_MAX = '1;
   localparam logic [CONF_W-1:0] CONF_MIN = '0;

   logic [CONF_W-1:0] line_conf [LINES];
   logic [CONF_W-1:0] conf_next;
   logic              conf_write;

   // Saturating step for the line under update
   always_comb begin
      conf_next  = up_conf;
      conf_write = 1'b0;
      unique case (up_op)
         CNT_UP: begin
            conf_write = 1'b1;
            if (up_conf != CONF_MAX) conf_next = up_conf + 1'b1;
         end
         CNT_DOWN: begin
            conf_write = 1'b1;
            if (up_conf != CONF_MIN) conf_next = up_conf - 1'b1;
         end
         default: begin
            conf_write = 1'b0;
         end
      endcase
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [CONF_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (conf_write && (up_idx == IDX_W'(g))) begin
            cnt_q <= conf_next;
         end
      end
      assign line_conf[g] = cnt_q;
   end

   assign rd_conf = line_conf[rd_idx];
   assign up_conf = line_conf[up_idx];

endmodule

// File: rtl/lastval_conf_predictor.sv
// Direct-mapped last-value load predictor with a saturating confidence
// counter per line and a run-time threshold (greater-or-equal rule).
module lastval_conf_predictor
   import cvp_pkg::*;
#(
   parameter  int LINES      = 64,
   parameter  int ADDR_W     = 32,
   parameter  int VALUE_W    = 64,
   parameter  int CONF_W     = 3,
   parameter  int ALIGN_BITS = 2,
   localparam int IDX_W      = $clog2(LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  lk_addr,
   input  logic [CONF_W-1:0]  thresh,
   output logic [VALUE_W-1:0] lk_value,
   output logic               lk_predict,
   input  logic               up_valid,
   input  logic [ADDR_W-1:0]  up_addr,
   input  logic [VALUE_W-1:0] up_value
);

   // Elaboration-time parameter checks
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("lastval_conf_predictor: LINES must be a power of two >= 2");
   end
   if (CONF_W < 1 || CONF_W > 8) begin : g_bad_conf
      $error("lastval_conf_predictor: CONF_W must be 1..8");
   end
   if (VALUE_W < 1) begin : g_bad_value
      $error("lastval_conf_predictor: VALUE_W must be positive");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [IDX_W-1:0]  up_idx;
   logic [CONF_W-1:0] lk_conf;
   logic [CONF_W-1:0] up_conf;
   logic              up_hit;
   cnt_op_e           cnt_op;

   cvp_index #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) lk_index_i (
      .addr (lk_addr),
      .idx  (lk_idx)
   );

   cvp_index #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) up_index_i (
      .addr (up_addr),
      .idx  (up_idx)
   );

   cvp_value_bank #(
      .LINES   (LINES),
      .VALUE_W (VALUE_W)
   ) value_bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_value (lk_value),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_value (up_value),
      .wr_match (up_hit)
   );

   always_comb begin
      if (!up_valid)   cnt_op = CNT_HOLD;
      else if (up_hit) cnt_op = CNT_UP;
      else             cnt_op = CNT_DOWN;
   end

   cvp_conf_bank #(
      .LINES  (LINES),
      .CONF_W (CONF_W)
   ) conf_bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_idx),
      .rd_conf (lk_conf),
      .up_idx  (up_idx),
      .up_op   (cnt_op),
      .up_conf (up_conf)
   );

   assign lk_predict = (lk_conf >= thresh);

endmodule

// File: rtl/cvp_checker.sv
// Temporal checks for the predictor, attached through bind.
module cvp_checker #(
   parameter int IDX_W   = 6,
   parameter int CONF_W  = 3,
   parameter int VALUE_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               up_valid,
   input logic [IDX_W-1:0]   up_idx,
   input logic [VALUE_W-1:0] up_value,
   input logic               up_hit,
   input logic [CONF_W-1:0]  up_conf,
   input logic [IDX_W-1:0]   lk_idx,
   input logic [VALUE_W-1:0] lk_value,
   input logic [CONF_W-1:0]  lk_conf,
   input logic [CONF_W-1:0]  thresh,
   input logic               lk_predict
);

   localparam logic [CONF_W-1:0] CMAX = '1;
   localparam logic [CONF_W-1:0] CMIN = '0;

   // R7
   value_replaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && lk_idx == $past(up_idx)) |-> lk_value == $past(up_value));

   // R4
   conf_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && $past(up_hit) && lk_idx == $past(up_idx) && $past(up_conf) != CMAX)
      |-> lk_conf == $past(up_conf) + 1'b1);

   // R5
   conf_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && !$past(up_hit) && lk_idx == $past(up_idx) && $past(up_conf) != CMIN)
      |-> lk_conf == $past(up_conf) - 1'b1);

   // R6
   conf_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && $past(up_hit) && lk_idx == $past(up_idx) && $past(up_conf) == CMAX)
      |-> lk_conf == CMAX);

   // R6
   conf_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && !$past(up_hit) && lk_idx == $past(up_idx) && $past(up_conf) == CMIN)
      |-> lk_conf == CMIN);

   // R8
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(up_valid) && $stable(lk_idx) && $stable(thresh))
      |-> ($stable(lk_value) && $stable(lk_predict)));

endmodule

bind lastval_conf_predictor cvp_checker #(
   .IDX_W   (IDX_W),
   .CONF_W  (CONF_W),
   .VALUE_W (VALUE_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .up_valid   (up_valid),
   .up_idx     (up_idx),
   .up_value   (up_value),
   .up_hit     (up_hit),
   .up_conf    (up_conf),
   .lk_idx     (lk_idx),
   .lk_value   (lk_value),
   .lk_conf    (lk_conf),
   .thresh     (thresh),
   .lk_predict (lk_predict)
);

// File: tb/lastval_conf_predictor_tb.sv
module lastval_conf_predictor_tb_top;

   localparam int LINES   = 16;
   localparam int ADDR_W  = 32;
   localparam int VALUE_W = 64;
   localparam int CONF_W  = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic [ADDR_W-1:0]  lk_addr;
   logic [CONF_W-1:0]  thresh;
   logic [VALUE_W-1:0] lk_value;
   logic               lk_predict;
   logic               up_valid;
   logic [ADDR_W-1:0]  up_addr;
   logic [VALUE_W-1:0] up_value;

   lastval_conf_predictor #(
      .LINES   (LINES),
      .ADDR_W  (ADDR_W),
      .VALUE_W (VALUE_W),
      .CONF_W  (CONF_W)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_addr    (lk_addr),
      .thresh     (thresh),
      .lk_value   (lk_value),
      .lk_predict (lk_predict),
      .up_valid   (up_valid),
      .up_addr    (up_addr),
      .up_value   (up_value)
   );

   // Reference model built from the requirements
   logic [VALUE_W-1:0] m_val [LINES];
   int                 m_cnt [LINES];
   int                 n_run  = 0;
   int                 n_fail = 0;
   bit                 done   = 0;

   function automatic int line_of(logic [ADDR_W-1:0] a);
      return int'((a >> 2) % LINES);
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One cycle: drive, check pre-edge outputs, clock, advance model
   task automatic step(bit uv, logic [ADDR_W-1:0] ua, logic [VALUE_W-1:0] ud,
                       logic [ADDR_W-1:0] la, logic [CONF_W-1:0] th, string req);
      int  li;
      int  ui;
      bit  ep;
      @(negedge clk);
      up_valid = uv; up_addr = ua; up_value = ud; lk_addr = la; thresh = th;
      #1;
      li = line_of(la);
      ep = (m_cnt[li] >= int'(th));
      chk(lk_value === m_val[li], {req, " value"}, lk_value, m_val[li]);
      chk(lk_predict === ep, {req, " predict"}, 64'(lk_predict), 64'(ep));
      @(posedge clk);
      if (uv) begin
         ui = line_of(ua);
         if (m_val[ui] == ud) m_cnt[ui] = (m_cnt[ui] == 7) ? 7 : m_cnt[ui] + 1;
         else                 m_cnt[ui] = (m_cnt[ui] == 0) ? 0 : m_cnt[ui] - 1;
         m_val[ui] = ud;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] ra;
      logic [ADDR_W-1:0] rl;
      void'($urandom(32'd20240611));
      for (int i = 0; i < LINES; i++) begin
         m_val[i] = '0;
         m_cnt[i] = 0;
      end
      rst_n = 1'b0; up_valid = 1'b0; up_addr = '0; up_value = '0;
      lk_addr = '0; thresh = 3'd1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: every line cleared after reset
      for (int i = 0; i < LINES; i++) step(1'b0, '0, '0, ADDR_W'(i * 4), 3'd1, "R2");

      // R1: aliasing through upper and low address bits
      step(1'b1, 32'h0000_1008, 64'hDEAD_BEEF_0000_0001, 32'h0, 3'd1, "R1");
      step(1'b0, '0, '0, 32'h0000_1008 + 32'(LINES * 4), 3'd1, "R1 alias");
      step(1'b0, '0, '0, 32'hABCD_0008, 3'd1, "R1 upper bits");
      step(1'b0, '0, '0, 32'h0000_100B, 3'd1, "R1 low bits");
      step(1'b0, '0, '0, 32'h0000_100C, 3'd1, "R1 next line");

      // R9: same-cycle lookup sees pre-update contents
      step(1'b1, 32'h14, 64'h55, 32'h14, 3'd1, "R9 same cycle");
      step(1'b1, 32'h14, 64'h55, 32'h14, 3'd1, "R9 after write");
      step(1'b0, '0, '0, 32'h14, 3'd1, "R9 new contents");

      // R6 floor, R4 climb, R6 ceiling on line 3
      step(1'b1, 32'h0C, 64'd5, 32'h0C, 3'd1, "R6 floor");
      for (int k = 0; k < 9; k++) step(1'b1, 32'h0C, 64'd5, 32'h0C, 3'd7, "R4 climb");
      step(1'b0, '0, '0, 32'h0C, 3'd7, "R6 ceiling");
      // R3: threshold sweep at full counter
      for (int t = 1; t < 8; t++) step(1'b0, '0, '0, 32'h0C, CONF_W'(t), "R3 sweep full");
      // R5 and R7: mismatch steps down once and replaces the value
      step(1'b1, 32'h0C, 64'd9, 32'h0C, 3'd7, "R5 mismatch");
      step(1'b0, '0, '0, 32'h0C, 3'd7, "R5 below seven");
      step(1'b0, '0, '0, 32'h0C, 3'd6, "R6 no wrap");
      step(1'b1, 32'h0C, 64'd9, 32'h0C, 3'd7, "R7 replaced value matches");
      step(1'b0, '0, '0, 32'h0C, 3'd7, "R4 back to seven");
      for (int k = 0; k < 9; k++)
         step(1'b1, 32'h0C, 64'(100 + k), 32'h0C, 3'd1, "R5 descend R7");
      for (int t = 1; t < 8; t++) step(1'b0, '0, '0, 32'h0C, CONF_W'(t), "R3 sweep empty");

      // R8: strobe low leaves line untouched
      step(1'b0, 32'h0C, 64'd777, 32'h0C, 3'd1, "R8 idle write");
      step(1'b0, 32'h0C, 64'd777, 32'h0C, 3'd1, "R8 still old");

      // R10: sweep all lines after updates to a few of them
      for (int i = 0; i < LINES; i++) step(1'b0, '0, '0, ADDR_W'(i * 4), 3'd1, "R10 sweep");

      // Random traffic: R3 R4 R5 R6 R7 R8 R10 against the model
      for (int n = 0; n < 4000; n++) begin
         ra = ($urandom & 32'hFFFF_FFC0) | ADDR_W'(($urandom % LINES) << 2) | ADDR_W'($urandom % 4);
         if ($urandom % 2 == 0) rl = ra ^ 32'h0001_0000;
         else rl = ($urandom & 32'hFFFF_FFC0) | ADDR_W'(($urandom % LINES) << 2);
         step(1'($urandom % 2), ra, 64'($urandom % 3), rl, CONF_W'(1 + $urandom % 7),
              "R3 R4 R5 R6 R10 random");
      end

      for (int i = 0; i < LINES; i++) step(1'b0, '0, '0, ADDR_W'(i * 4), 3'd4, "R10 final sweep");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule